// File: doc/BRIEF.md
# Multi-Cycle Integer Multiplier Unit

This block multiplies two operand words and delivers the product after a fixed, mode-dependent number of clock cycles. A full-width mode forms the double-width product and splits it across a high and a low result register. A half-width mode multiplies only the lower halves of the operands and writes the single-width product to the low result register, leaving the high register alone. Each width comes in a signed (two's complement) and an unsigned flavour, chosen by one select input sampled with the start strobe.

When it finishes, the unit raises a one-cycle done pulse. In the same cycle it presents negative, zero and overflow flag values with per-flag update enables, so that a surrounding status register can merge them. Which enables fire depends on the width mode. Operands are captured on an accepted start. A start that arrives while an operation is in flight is dropped.

Top module: `imul_unit`

## Requirements
- R1: In full mode (is_wide=1), {res_hi, res_lo} receives the 64-bit product of op_a and op_b, both read as two's complement when is_signed=1 and as unsigned when is_signed=0.
- R2: In half mode (is_wide=0), only op_a[15:0] and op_b[15:0] are used, sign-extended when is_signed=1 and zero-extended otherwise, and res_lo receives the 32-bit product. Bits 31:16 of the operands have no effect.
- R3: A half-mode operation leaves res_hi and flag_v unchanged.
- R4: If start is sampled at clock edge t while the unit is idle, done is high after edge t+5 in full mode and after edge t+3 in half mode.
- R5: done is high for exactly one cycle. The result registers and flags change only at the edge that raises done, and they hold afterwards until a later operation completes.
- R6: On a full-mode completion, flag_n is product bit 63 and flag_z is set when all 64 product bits are zero. flag_v is set when the product does not fit in res_lo: for signed, res_hi differs from 32 copies of res_lo bit 31; for unsigned, res_hi is nonzero. upd_n, upd_z and upd_v are all high with done.
- R7: On a half-mode completion, flag_n is product bit 31 and flag_z is set when the 32-bit product is zero. upd_n and upd_z are high with done and upd_v stays low.
- R8: A start sampled while an operation is in flight, including at the edge that completes it, is ignored and does not alter that operation's result.
- R9: After reset, res_hi, res_lo, all flags, all update enables and done are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| is_signed | input | 1 | 1: two's complement, 0: unsigned |
| is_wide | input | 1 | 1: 32x32 full mode, 0: 16x16 half mode |
| res_hi | output | 32 | Upper half of full-mode product |
| res_lo | output | 32 | Lower half / half-mode product |
| flag_n | output | 1 | Negative flag value |
| flag_z | output | 1 | Zero flag value |
| flag_v | output | 1 | Overflow flag value |
| upd_n | output | 1 | Write enable for flag_n |
| upd_z | output | 1 | Write enable for flag_z |
| upd_v | output | 1 | Write enable for flag_v |
| done | output | 1 | One-cycle completion pulse |

## Verification
The completion of an operation and the arrival of a fresh start can fall in the same cycle, as can the busy window and a stray start. The bench drives a second start with different operands and the opposite width mode, both in the middle of an operation and exactly at its completing edge. It then judges that the finished result equals the first operation's expected product and that no second done pulse or result change follows in the next several cycles.

// File: rtl/imul_pkg.sv
package imul_pkg;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
   } imul_flags_t;

   localparam int ARCH_EXTEND = 0;
   localparam int ARCH_MAGNITUDE = 1;

endpackage

// File: rtl/imul_ctrl.sv
module imul_ctrl #(
   parameter int LAT_WIDE = 5,
   parameter int LAT_HALF = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic is_wide,
   output logic busy,
   output logic accept,
   output logic finish
);
   localparam int LMAX = (LAT_WIDE > LAT_HALF) ? LAT_WIDE : LAT_HALF;
   localparam int CW = $clog2(LMAX) + 1;
   localparam logic [CW-1:0] LOAD_W = CW'(LAT_WIDE - 1);
   localparam logic [CW-1:0] LOAD_H = CW'(LAT_HALF - 1);

   logic [CW-1:0] cnt;

   assign accept = start && !busy;
   assign finish = busy && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (accept) begin
         busy <= 1'b1;
         cnt  <= is_wide ? LOAD_W : LOAD_H;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/imul_array.sv
module imul_array #(
   parameter int DW   = 32,
   parameter int ARCH = 0
) (
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   input  logic            sgn,
   output logic [2*DW-1:0] prod
);
   generate
      if (ARCH == imul_pkg::ARCH_EXTEND) begin : g_extend
         logic [2*DW-1:0] ae, be;
         assign ae   = sgn ? {{DW{a[DW-1]}}, a} : {{DW{1'b0}}, a};
         assign be   = sgn ? {{DW{b[DW-1]}}, b} : {{DW{1'b0}}, b};
         assign prod = ae * be;
      end else begin : g_magnitude
         logic [DW-1:0]   ma, mb;
         logic [2*DW-1:0] mp;
         logic            neg;
         assign ma   = (sgn && a[DW-1]) ? (~a + 1'b1) : a;
         assign mb   = (sgn && b[DW-1]) ? (~b + 1'b1) : b;
         assign mp   = {{DW{1'b0}}, ma} * {{DW{1'b0}}, mb};
         assign neg  = sgn && (a[DW-1] ^ b[DW-1]);
         assign prod = neg ? (~mp + 1'b1) : mp;
      end
   endgenerate
endmodule

// File: rtl/imul_flag.sv
module imul_flag #(
   parameter int DW = 32
) (
   input  logic [2*DW-1:0]         prod,
   input  logic                    wide,
   input  logic                    sgn,
   output imul_pkg::imul_flags_t   fl
);
   logic [DW-1:0] hi, lo;
   assign hi = prod[2*DW-1:DW];
   assign lo = prod[DW-1:0];

   always_comb begin
      if (wide) begin
         fl.n = hi[DW-1];
         fl.z = (prod == '0);
         fl.v = sgn ? (hi != {DW{lo[DW-1]}}) : (hi != '0);
      end else begin
         fl.n = lo[DW-1];
         fl.z = (lo == '0);
         fl.v = 1'b0;
      end
   end
endmodule

// File: rtl/imul_unit.sv
module imul_unit #(
   parameter int DW       = 32,
   parameter int LAT_WIDE = 5,
   parameter int LAT_HALF = 3,
   parameter int ARCH     = imul_pkg::ARCH_EXTEND
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] op_a,
   input  logic [DW-1:0] op_b,
   input  logic          is_signed,
   input  logic          is_wide,
   output logic [DW-1:0] res_hi,
   output logic [DW-1:0] res_lo,
   output logic          flag_n,
   output logic          flag_z,
   output logic          flag_v,
   output logic          upd_n,
   output logic          upd_z,
   output logic          upd_v,
   output logic          done
);
   localparam int HW = DW / 2;

   generate
      if (DW < 2 || (DW % 2) != 0) begin : g_bad_dw
         $error("imul_unit: DW must be even and at least 2");
      end
      if (LAT_WIDE < 1 || LAT_HALF < 1) begin : g_bad_lat
         $error("imul_unit: latencies must be at least 1");
      end
      if (ARCH != imul_pkg::ARCH_EXTEND && ARCH != imul_pkg::ARCH_MAGNITUDE) begin : g_bad_arch
         $error("imul_unit: unknown ARCH");
      end
   endgenerate

   logic                  busy, accept, finish;
   logic [DW-1:0]         opa_q, opb_q;
   logic                  sgn_q, wide_q;
   logic [DW-1:0]         a_in, b_in;
   logic [2*DW-1:0]       prod;
   imul_pkg::imul_flags_t fl;

   // half mode: extend the lower half before capture so one array serves both widths
   assign a_in = is_wide ? op_a :
                 (is_signed ? {{HW{op_a[HW-1]}}, op_a[HW-1:0]} : {{HW{1'b0}}, op_a[HW-1:0]});
   assign b_in = is_wide ? op_b :
                 (is_signed ? {{HW{op_b[HW-1]}}, op_b[HW-1:0]} : {{HW{1'b0}}, op_b[HW-1:0]});

   imul_ctrl #(.LAT_WIDE(LAT_WIDE), .LAT_HALF(LAT_HALF)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .is_wide(is_wide),
      .busy(busy), .accept(accept), .finish(finish)
   );

   imul_array #(.DW(DW), .ARCH(ARCH)) u_array (
      .a(opa_q), .b(opb_q), .sgn(sgn_q), .prod(prod)
   );

   imul_flag #(.DW(DW)) u_flag (
      .prod(prod), .wide(wide_q), .sgn(sgn_q), .fl(fl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opa_q  <= '0;
         opb_q  <= '0;
         sgn_q  <= 1'b0;
         wide_q <= 1'b0;
      end else if (accept) begin
         opa_q  <= a_in;
         opb_q  <= b_in;
         sgn_q  <= is_signed;
         wide_q <= is_wide;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_hi <= '0;
         res_lo <= '0;
         flag_n <= 1'b0;
         flag_z <= 1'b0;
         flag_v <= 1'b0;
      end else if (finish) begin
         res_lo <= prod[DW-1:0];
         flag_n <= fl.n;
         flag_z <= fl.z;
         if (wide_q) begin
            res_hi <= prod[2*DW-1:DW];
            flag_v <= fl.v;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done  <= 1'b0;
         upd_n <= 1'b0;
         upd_z <= 1'b0;
         upd_v <= 1'b0;
      end else begin
         done  <= finish;
         upd_n <= finish;
         upd_z <= finish;
         upd_v <= finish && wide_q;
      end
   end
endmodule

// File: rtl/imul_unit_chk.sv
module imul_unit_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          done,
   input logic [DW-1:0] res_hi,
   input logic [DW-1:0] res_lo,
   input logic          flag_v,
   input logic          upd_n,
   input logic          upd_z,
   input logic          upd_v,
   input logic          busy,
   input logic          wide_q,
   input logic [DW-1:0] opa_q
);
   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(res_lo) |-> done);

   // R3
   hi_half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !wide_q) |-> ($stable(res_hi) && $stable(flag_v)));

   // R7
   upd_v_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_v |-> (done && wide_q));

   // R6
   upd_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (upd_n && upd_z));

   // R8
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(opa_q));
endmodule

bind imul_unit imul_unit_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_imul_unit.sv
`timescale 1ns/1ps
module sim_imul_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] op_a = '0, op_b = '0;
   logic        is_signed = 1'b0, is_wide = 1'b0;
   logic [31:0] res_hi, res_lo;
   logic        flag_n, flag_z, flag_v, upd_n, upd_z, upd_v, done;

   int total = 0;
   int fails = 0;
   logic [31:0] exp_hi = '0;
   logic        exp_v = 1'b0;

   always #10 clk = ~clk;

   imul_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
      .is_signed(is_signed), .is_wide(is_wide), .res_hi(res_hi), .res_lo(res_lo),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
      .upd_n(upd_n), .upd_z(upd_z), .upd_v(upd_v), .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b,
                                            input logic s, input logic w);
      logic [63:0] ea, eb;
      if (w) begin
         ea = s ? {{32{a[31]}}, a} : {32'b0, a};
         eb = s ? {{32{b[31]}}, b} : {32'b0, b};
      end else begin
         ea = s ? {{48{a[15]}}, a[15:0]} : {48'b0, a[15:0]};
         eb = s ? {{48{b[15]}}, b[15:0]} : {48'b0, b[15:0]};
      end
      return ea * eb;
   endfunction

   // inj_k >= 0: drive an extra start so it is sampled at edge t+inj_k+1
   task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                         input logic s, input logic w, input int inj_k);
      logic [63:0] p;
      logic        en, ez, ev;
      logic [31:0] elo, ehi;
      int k;
      bit seen;
      p = ref_prod(a, b, s, w);
      elo = p[31:0];
      if (w) begin
         ehi = p[63:32];
         en = p[63];
         ez = (p == 64'd0);
         ev = s ? (p[63:32] != {32{p[31]}}) : (p[63:32] != 32'd0);
      end else begin
         ehi = exp_hi;
         en = p[31];
         ez = (p[31:0] == 32'd0);
         ev = exp_v;
      end
      @(negedge clk);
      op_a = a; op_b = b; is_signed = s; is_wide = w; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      k = 0;
      seen = 0;
      while (k < 12 && !seen) begin
         if (k == inj_k) begin
            start = 1'b1; op_a = ~a; op_b = b + 32'd3; is_wide = ~w; is_signed = ~s;
         end
         @(posedge clk);
         k++;
         @(negedge clk);
         start = 1'b0;
         if (done) seen = 1;
      end
      chk(seen && k == (w ? 5 : 3), "R4", "latency", 64'(k), 64'(w ? 5 : 3));
      chk(res_lo == elo, w ? "R1" : "R2", "res_lo", {32'b0, res_lo}, {32'b0, elo});
      chk(res_hi == ehi, w ? "R1" : "R3", "res_hi", {32'b0, res_hi}, {32'b0, ehi});
      chk(flag_n == en && flag_z == ez, w ? "R6" : "R7", "flags nz",
          {62'b0, flag_n, flag_z}, {62'b0, en, ez});
      chk(flag_v == ev, w ? "R6" : "R3", "flag_v", {63'b0, flag_v}, {63'b0, ev});
      chk(upd_n && upd_z && (upd_v == w), w ? "R6" : "R7", "update enables",
          {61'b0, upd_n, upd_z, upd_v}, {61'b0, 1'b1, 1'b1, w});
      exp_hi = ehi;
      exp_v = ev;
      if (inj_k >= 0) begin
         seen = 0;
         for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (done) seen = 1;
         end
         chk(!seen && res_lo == elo && res_hi == ehi, "R8", "stray start ignored",
             {res_hi, res_lo}, {ehi, elo});
      end else begin
         @(negedge clk);
         chk(!done, "R5", "done one cycle", {63'b0, done}, 64'd0);
         @(negedge clk);
         chk(res_lo == elo && res_hi == ehi, "R5", "results hold",
             {res_hi, res_lo}, {ehi, elo});
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] ra, rb;
      void'($urandom(32'd1977));
      repeat (3) @(negedge clk);
      chk(res_hi == 0 && res_lo == 0 && !done && !flag_n && !flag_z && !flag_v
          && !upd_n && !upd_z && !upd_v, "R9", "reset state",
          {res_hi, res_lo}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners
      run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, -1); // R1 R6 large positive, V
      run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, -1); // R1 unsigned V
      run_op(32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 1'b1, -1); // R6 negative, no V
      run_op(32'h0001_0000, 32'h0001_0000, 1'b0, 1'b1, -1); // R6 res_lo zero but Z clear
      run_op(32'h0000_0000, 32'h1234_5678, 1'b1, 1'b1, -1); // R6 zero product
      run_op(32'hABCD_8000, 32'h5555_8000, 1'b1, 1'b0, -1); // R2 upper bits ignored
      run_op(32'h1234_FFFF, 32'h0000_0001, 1'b1, 1'b0, -1); // R7 half negative
      run_op(32'h0000_FFFF, 32'h0000_FFFF, 1'b0, 1'b0, -1); // R2 unsigned half
      run_op(32'hFFFF_0000, 32'h0000_7777, 1'b0, 1'b0, -1); // R7 half zero
      run_op(32'h7FFF_FFFF, 32'h0000_0003, 1'b1, 1'b1, 1);  // R8 mid-flight start
      run_op(32'h0000_1234, 32'h0000_4321, 1'b0, 1'b0, 2);  // R8 start at completing edge
      run_op(32'hDEAD_BEEF, 32'h0000_0002, 1'b0, 1'b1, 4);  // R8 start at completing edge, full
      for (int i = 0; i < 80; i++) begin
         ra = $urandom;
         rb = $urandom;
         if (i % 7 == 0) rb = rb & 32'h0000_00FF;
         run_op(ra, rb, 1'($urandom), 1'($urandom), -1);
      end
      finish_run();
   end
endmodule